// File: doc/BRIEF.md
# Memory Port Width Down-Converter

This block joins a wide user-side memory port to a narrower native memory port. The wide word is a power-of-two multiple of the narrow word. Each side has three channels:

- a command channel carrying valid, ready, write flag and address;
- a write-data channel carrying valid, ready, data and byte mask;
- a read-data channel carrying valid, ready and data.

A wide write is broken into one narrow write per sub-word. Each narrow write carries its own address, data slice and mask slice. A wide read is broken into one narrow read per sub-word, and the narrow returns are packed into a single wide result.

Only one user transaction is in flight at a time. For a write, the user drives the command and the write data together and holds both. The block acknowledges the command only after every narrow piece has been handed to the native side. It then acknowledges the data on the following cycle.

A ratio of one turns the block into a pass-through with the same handshakes. A configuration whose widths do not divide to a power of two is rejected when the design is built. So is a narrow width that is not a whole number of bytes. A user that has no byte mask ties the mask input to all ones.

Top module: `mem_port_downsizer`

## Requirements
- R1: With RATIO = WIDE_W / NARROW_W, a transaction at user address A produces RATIO narrow commands. Their addresses are A*RATIO + i, issued in the order i = 0, 1, ..., RATIO-1.
- R2: Narrow write i carries wide data bits [i*NARROW_W +: NARROW_W] and wide mask bits [i*NARROW_W/8 +: NARROW_W/8]. Mask bit b enables byte b, counted from the least significant byte.
- R3: For a write, u_cmd_ready is high for exactly one cycle, after all RATIO narrow command and data handshakes have completed. u_wr_ready is low during that cycle and high for exactly the following cycle.
- R4: A read issues RATIO narrow commands with n_cmd_we = 0 and yields exactly one wide beat on u_rd_valid. The k-th narrow return, in arrival order, lands in wide bits [k*NARROW_W +: NARROW_W].
- R5: Once u_rd_valid is high, it stays high and u_rd_data stays unchanged until a cycle with u_rd_ready high.
- R6: While n_cmd_valid or n_wr_valid is high and its ready is low, the valid stays high and the command address or write data stays unchanged in the next cycle.
- R7: While a transaction is unfinished, the block accepts no new user command. In particular, while a wide read result waits, u_cmd_ready and n_cmd_valid stay low even if u_cmd_valid is high.
- R8: After reset, all valid and ready outputs of the block are low.
- R9: A write command (u_cmd_valid with u_cmd_we = 1) starts nothing while u_wr_valid is low. No narrow command is issued and u_cmd_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| u_cmd_valid | input | 1 | User command valid |
| u_cmd_ready | output | 1 | User command accepted |
| u_cmd_we | input | 1 | User command is a write |
| u_cmd_addr | input | ADDR_W | User word address |
| u_wr_valid | input | 1 | User write data valid |
| u_wr_ready | output | 1 | User write data accepted |
| u_wr_data | input | WIDE_W | User write data |
| u_wr_mask | input | WIDE_W/8 | User byte enables |
| u_rd_valid | output | 1 | Wide read result valid |
| u_rd_ready | input | 1 | User takes read result |
| u_rd_data | output | WIDE_W | Wide read result |
| n_cmd_valid | output | 1 | Narrow command valid |
| n_cmd_ready | input | 1 | Narrow command accepted |
| n_cmd_we | output | 1 | Narrow command is a write |
| n_cmd_addr | output | ADDR_W+log2(RATIO) | Narrow word address |
| n_wr_valid | output | 1 | Narrow write data valid |
| n_wr_ready | input | 1 | Narrow write data accepted |
| n_wr_data | output | NARROW_W | Narrow write data slice |
| n_wr_mask | output | NARROW_W/8 | Narrow byte enables |
| n_rd_valid | input | 1 | Narrow read return valid |
| n_rd_ready | output | 1 | Block takes narrow return |
| n_rd_data | input | NARROW_W | Narrow read return data |

## Verification
A wrong sub-word counter shows up at the native port at once. The very next narrow command carries an address or data slice that the bench's per-cycle expected stream rejects. A bad pack register or return count shows up only when the wide read beat is presented, one transaction later, as a wrong slice in u_rd_data or a missing beat. A state machine that leaves a handshake early shows up within a cycle, as u_cmd_ready arriving before all native beats, or as u_wr_ready out of step with it. The final comparison of narrow memory against the wide reference exposes any slice or mask that was lost without being read back.

// File: rtl/mpdc_pkg.sv
// Shared types for the memory port down-converter.
// Assumes: nothing beyond the parameters of the block using it.
package mpdc_pkg;

    // Transaction phases of the down-converter control
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_WR_BEAT   = 3'd1,
        ST_WR_CMDACK = 3'd2,
        ST_WR_DATACK = 3'd3,
        ST_RD_RUN    = 3'd4,
        ST_RD_HOLD   = 3'd5
    } mpdc_state_e;

    // True when v is a power of two (one counts as two to the zero)
    function automatic bit mpdc_is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/mpdc_ctrl.sv
// Control for the memory port down-converter.
// Sequences one user transaction at a time into RATIO narrow beats.
// Writes: waits for command and data together, then issues each beat as a
// narrow command plus a narrow data transfer, in either order. Once all are
// done, it acknowledges the command and then the data.
// Reads: issues RATIO narrow reads, counts returns and presents one wide beat.
// Assumes: the native side returns reads in order and never returns more than
// it was asked for; the user holds valid signals until they are acknowledged.
module mpdc_ctrl
    import mpdc_pkg::*;
#(
    parameter  int RATIO = 4,
    localparam int CNT_W = $clog2(RATIO + 1),
    localparam int IDX_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             u_cmd_valid,
    input  logic             u_cmd_we,
    input  logic             u_wr_valid,
    input  logic             u_rd_ready,
    input  logic             n_cmd_ready,
    input  logic             n_wr_ready,
    input  logic             n_rd_valid,
    output logic             u_cmd_ready,
    output logic             u_wr_ready,
    output logic             u_rd_valid,
    output logic             n_cmd_valid,
    output logic             n_cmd_we,
    output logic             n_wr_valid,
    output logic             n_rd_ready,
    output logic             load,
    output logic             ret_take,
    output logic [IDX_W-1:0] sub_idx
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(RATIO - 1);
    localparam logic [CNT_W-1:0] ALL_IDX  = CNT_W'(RATIO);

    mpdc_state_e      st;
    logic [CNT_W-1:0] sub_cnt;
    logic [CNT_W-1:0] ret_cnt;
    logic             cmd_sent;
    logic             dat_sent;
    logic             cmd_fire;
    logic             dat_fire;
    logic             beat_done;

    // Handshake outputs decoded from the current phase
    always_comb begin
        load        = (st == ST_IDLE) && u_cmd_valid && (!u_cmd_we || u_wr_valid);
        u_cmd_ready = ((st == ST_IDLE) && u_cmd_valid && !u_cmd_we) || (st == ST_WR_CMDACK);
        u_wr_ready  = (st == ST_WR_DATACK);
        u_rd_valid  = (st == ST_RD_HOLD);
        n_cmd_we    = (st == ST_WR_BEAT);
        n_cmd_valid = ((st == ST_WR_BEAT) && !cmd_sent) ||
                      ((st == ST_RD_RUN) && (sub_cnt != ALL_IDX));
        n_wr_valid  = (st == ST_WR_BEAT) && !dat_sent;
        n_rd_ready  = (st == ST_RD_RUN) && (ret_cnt != ALL_IDX);
        cmd_fire    = n_cmd_valid && n_cmd_ready;
        dat_fire    = n_wr_valid && n_wr_ready;
        beat_done   = (cmd_sent || cmd_fire) && (dat_sent || dat_fire);
        ret_take    = n_rd_valid && n_rd_ready;
        sub_idx     = sub_cnt[IDX_W-1:0];
    end

    // Phase register, sub-word counters and per-beat handshake flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            sub_cnt  <= '0;
            ret_cnt  <= '0;
            cmd_sent <= 1'b0;
            dat_sent <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (load) begin
                        st       <= u_cmd_we ? ST_WR_BEAT : ST_RD_RUN;
                        sub_cnt  <= '0;
                        ret_cnt  <= '0;
                        cmd_sent <= 1'b0;
                        dat_sent <= 1'b0;
                    end
                end
                ST_WR_BEAT: begin
                    if (beat_done) begin
                        cmd_sent <= 1'b0;
                        dat_sent <= 1'b0;
                        if (sub_cnt == LAST_IDX) begin
                            st <= ST_WR_CMDACK;
                        end else begin
                            sub_cnt <= sub_cnt + 1'b1;
                        end
                    end else begin
                        if (cmd_fire) cmd_sent <= 1'b1;
                        if (dat_fire) dat_sent <= 1'b1;
                    end
                end
                ST_WR_CMDACK: st <= ST_WR_DATACK;
                ST_WR_DATACK: st <= ST_IDLE;
                ST_RD_RUN: begin
                    if (cmd_fire) sub_cnt <= sub_cnt + 1'b1;
                    if (ret_take) begin
                        ret_cnt <= ret_cnt + 1'b1;
                        if (ret_cnt == LAST_IDX) st <= ST_RD_HOLD;
                    end
                end
                ST_RD_HOLD: begin
                    if (u_rd_ready) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_DATA_ACK_AFTER_CMD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        u_wr_ready |-> $past(u_cmd_ready)) else $error("data ack without command ack"); // R3
    AST_RD_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        u_rd_valid && !u_rd_ready |=> u_rd_valid) else $error("read result dropped"); // R5
    AST_NCMD_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        n_cmd_valid && !n_cmd_ready |=> n_cmd_valid) else $error("narrow command dropped"); // R6
    AST_NWR_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        n_wr_valid && !n_wr_ready |=> n_wr_valid) else $error("narrow data dropped"); // R6
    AST_QUIET_WHILE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        u_rd_valid |-> !n_cmd_valid && !n_rd_ready && !u_cmd_ready) else $error("activity while result pending"); // R7
    AST_SUB_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        sub_cnt <= ALL_IDX && ret_cnt <= ALL_IDX) else $error("sub-word counter overran"); // R1

endmodule

// File: rtl/mpdc_wslice.sv
// Write and address path for the memory port down-converter.
// Captures the user address, data and mask when a transaction is loaded.
// Presents the narrow address, data slice and mask slice for the current
// sub-word index. Sub-word 0 is the least significant slice.
// Assumes: load is only raised while the user inputs are valid.
module mpdc_wslice #(
    parameter  int WIDE_W   = 64,
    parameter  int NARROW_W = 16,
    parameter  int ADDR_W   = 16,
    localparam int RATIO    = WIDE_W / NARROW_W,
    localparam int LOG2R    = $clog2(RATIO),
    localparam int IDX_W    = (RATIO > 1) ? LOG2R : 1,
    localparam int NADDR_W  = ADDR_W + LOG2R,
    localparam int WB       = WIDE_W / 8,
    localparam int NB       = NARROW_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [ADDR_W-1:0]   u_addr,
    input  logic [WIDE_W-1:0]   u_data,
    input  logic [WB-1:0]       u_mask,
    input  logic [IDX_W-1:0]    sub_idx,
    output logic [NADDR_W-1:0]  n_addr,
    output logic [NARROW_W-1:0] n_data,
    output logic [NB-1:0]       n_mask
);

    logic [ADDR_W-1:0] addr_q;
    logic [WIDE_W-1:0] data_q;
    logic [WB-1:0]     mask_q;

    // Capture the user transaction at load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            mask_q <= '0;
        end else if (load) begin
            addr_q <= u_addr;
            data_q <= u_data;
            mask_q <= u_mask;
        end
    end

    // Select the data and mask slices of the current sub-word
    always_comb begin
        n_data = data_q[int'(sub_idx) * NARROW_W +: NARROW_W];
        n_mask = mask_q[int'(sub_idx) * NB +: NB];
    end

    // Narrow address: user address scaled by the ratio plus the sub-word index
    generate
        if (LOG2R > 0) begin : g_scaled_addr
            assign n_addr = {addr_q, sub_idx[LOG2R-1:0]};
        end else begin : g_same_addr
            assign n_addr = addr_q;
        end
    endgenerate

endmodule

// File: rtl/mpdc_rpack.sv
// Read packing path for the memory port down-converter.
// Each accepted narrow return is shifted in from the top, so that after
// RATIO returns the first one sits in the least significant slice.
// Assumes: take is raised once per narrow return accepted.
module mpdc_rpack #(
    parameter  int WIDE_W   = 64,
    parameter  int NARROW_W = 16,
    localparam int RATIO    = WIDE_W / NARROW_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [NARROW_W-1:0] n_data,
    output logic [WIDE_W-1:0]   wide_data
);

    logic [WIDE_W-1:0] acc_q;

    // Shift each narrow return into the wide accumulator
    generate
        if (RATIO > 1) begin : g_shift
            always_ff @(posedge clk) begin
                if (!rst_n) acc_q <= '0;
                else if (take) acc_q <= {n_data, acc_q[WIDE_W-1:NARROW_W]};
            end
        end else begin : g_direct
            always_ff @(posedge clk) begin
                if (!rst_n) acc_q <= '0;
                else if (take) acc_q <= n_data;
            end
        end
    endgenerate

    assign wide_data = acc_q;

endmodule

// File: rtl/mem_port_downsizer.sv
// Memory port width down-converter, top level.
// Connects a WIDE_W user port to a NARROW_W native port. RATIO is
// WIDE_W / NARROW_W and must be a power of two (one gives a pass-through).
// A write becomes RATIO narrow writes; a read becomes RATIO narrow reads
// packed into one wide result. One transaction is handled at a time.
// Assumes: user write command and data are presented together and held;
// native read returns arrive in command order.
module mem_port_downsizer
    import mpdc_pkg::*;
#(
    parameter  int WIDE_W   = 64,
    parameter  int NARROW_W = 16,
    parameter  int ADDR_W   = 16,
    localparam int RATIO    = WIDE_W / NARROW_W,
    localparam int LOG2R    = $clog2(RATIO),
    localparam int IDX_W    = (RATIO > 1) ? LOG2R : 1,
    localparam int NADDR_W  = ADDR_W + LOG2R,
    localparam int WB       = WIDE_W / 8,
    localparam int NB       = NARROW_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                u_cmd_valid,
    output logic                u_cmd_ready,
    input  logic                u_cmd_we,
    input  logic [ADDR_W-1:0]   u_cmd_addr,
    input  logic                u_wr_valid,
    output logic                u_wr_ready,
    input  logic [WIDE_W-1:0]   u_wr_data,
    input  logic [WB-1:0]       u_wr_mask,
    output logic                u_rd_valid,
    input  logic                u_rd_ready,
    output logic [WIDE_W-1:0]   u_rd_data,
    output logic                n_cmd_valid,
    input  logic                n_cmd_ready,
    output logic                n_cmd_we,
    output logic [NADDR_W-1:0]  n_cmd_addr,
    output logic                n_wr_valid,
    input  logic                n_wr_ready,
    output logic [NARROW_W-1:0] n_wr_data,
    output logic [NB-1:0]       n_wr_mask,
    input  logic                n_rd_valid,
    output logic                n_rd_ready,
    input  logic [NARROW_W-1:0] n_rd_data
);

    // Reject widths that do not divide to a power of two or are not byte sized
    generate
        if ((WIDE_W % NARROW_W) != 0 || !mpdc_is_pow2(RATIO) || (NARROW_W % 8) != 0) begin : g_bad_widths
            $error("width ratio must be an integer power of two with byte-sized words");
        end
    endgenerate

    logic             load;
    logic             ret_take;
    logic [IDX_W-1:0] sub_idx;

    mpdc_ctrl #(
        .RATIO (RATIO)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .u_cmd_valid (u_cmd_valid),
        .u_cmd_we    (u_cmd_we),
        .u_wr_valid  (u_wr_valid),
        .u_rd_ready  (u_rd_ready),
        .n_cmd_ready (n_cmd_ready),
        .n_wr_ready  (n_wr_ready),
        .n_rd_valid  (n_rd_valid),
        .u_cmd_ready (u_cmd_ready),
        .u_wr_ready  (u_wr_ready),
        .u_rd_valid  (u_rd_valid),
        .n_cmd_valid (n_cmd_valid),
        .n_cmd_we    (n_cmd_we),
        .n_wr_valid  (n_wr_valid),
        .n_rd_ready  (n_rd_ready),
        .load        (load),
        .ret_take    (ret_take),
        .sub_idx     (sub_idx)
    );

    mpdc_wslice #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W),
        .ADDR_W   (ADDR_W)
    ) i_wslice (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .u_addr  (u_cmd_addr),
        .u_data  (u_wr_data),
        .u_mask  (u_wr_mask),
        .sub_idx (sub_idx),
        .n_addr  (n_cmd_addr),
        .n_data  (n_wr_data),
        .n_mask  (n_wr_mask)
    );

    mpdc_rpack #(
        .WIDE_W   (WIDE_W),
        .NARROW_W (NARROW_W)
    ) i_rpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (ret_take),
        .n_data    (n_rd_data),
        .wide_data (u_rd_data)
    );

    AST_NCMD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        n_cmd_valid && !n_cmd_ready |=> $stable(n_cmd_addr) && $stable(n_cmd_we)) else $error("narrow command changed under stall"); // R6
    AST_NWR_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        n_wr_valid && !n_wr_ready |=> $stable(n_wr_data) && $stable(n_wr_mask)) else $error("narrow data changed under stall"); // R6
    AST_RD_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        u_rd_valid && !u_rd_ready |=> $stable(u_rd_data)) else $error("read result changed while held"); // R5
    AST_WRITE_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(n_cmd_valid) && n_cmd_we |-> $past(u_wr_valid)) else $error("write started without data"); // R9

endmodule

// File: tb/test_mem_port_downsizer.sv
`timescale 1ns/1ps
module test_mem_port_downsizer;

    localparam int WIDE_W   = 64;
    localparam int NARROW_W = 16;
    localparam int ADDR_W   = 16;
    localparam int RATIO    = WIDE_W / NARROW_W;
    localparam int NADDR_W  = ADDR_W + $clog2(RATIO);
    localparam int WB       = WIDE_W / 8;
    localparam int NB       = NARROW_W / 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                u_cmd_valid = 1'b0;
    logic                u_cmd_ready;
    logic                u_cmd_we = 1'b0;
    logic [ADDR_W-1:0]   u_cmd_addr = '0;
    logic                u_wr_valid = 1'b0;
    logic                u_wr_ready;
    logic [WIDE_W-1:0]   u_wr_data = '0;
    logic [WB-1:0]       u_wr_mask = '0;
    logic                u_rd_valid;
    logic                u_rd_ready = 1'b0;
    logic [WIDE_W-1:0]   u_rd_data;
    logic                n_cmd_valid;
    logic                n_cmd_ready = 1'b0;
    logic                n_cmd_we;
    logic [NADDR_W-1:0]  n_cmd_addr;
    logic                n_wr_valid;
    logic                n_wr_ready = 1'b0;
    logic [NARROW_W-1:0] n_wr_data;
    logic [NB-1:0]       n_wr_mask;
    logic                n_rd_valid = 1'b0;
    logic                n_rd_ready;
    logic [NARROW_W-1:0] n_rd_data = '0;

    always #2.5 clk = ~clk;

    mem_port_downsizer #(
        .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W)
    ) i_mem_port_downsizer (
        .clk(clk), .rst_n(rst_n),
        .u_cmd_valid(u_cmd_valid), .u_cmd_ready(u_cmd_ready), .u_cmd_we(u_cmd_we), .u_cmd_addr(u_cmd_addr),
        .u_wr_valid(u_wr_valid), .u_wr_ready(u_wr_ready), .u_wr_data(u_wr_data), .u_wr_mask(u_wr_mask),
        .u_rd_valid(u_rd_valid), .u_rd_ready(u_rd_ready), .u_rd_data(u_rd_data),
        .n_cmd_valid(n_cmd_valid), .n_cmd_ready(n_cmd_ready), .n_cmd_we(n_cmd_we), .n_cmd_addr(n_cmd_addr),
        .n_wr_valid(n_wr_valid), .n_wr_ready(n_wr_ready), .n_wr_data(n_wr_data), .n_wr_mask(n_wr_mask),
        .n_rd_valid(n_rd_valid), .n_rd_ready(n_rd_ready), .n_rd_data(n_rd_data)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Expected narrow stream, built from the user transactions
    int                  exp_addr[$];
    bit                  exp_we[$];
    logic [NARROW_W-1:0] exp_dat[$];
    logic [NB-1:0]       exp_msk[$];
    // Native memory model
    int                  rq[$];
    int                  wqa[$];
    logic [NARROW_W-1:0] wqd[$];
    logic [NB-1:0]       wqm[$];
    logic [NARROW_W-1:0] nmem[int];
    // Wide reference model
    logic [WIDE_W-1:0]   wref[int];
    int                  nwr_beats = 0;
    bit                  prev_stall = 1'b0;
    logic [NADDR_W-1:0]  prev_addr = '0;
    bit                  rd_taken = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Native memory responder and per-cycle comparison against the expected stream
    always @(negedge clk) begin
        if (!rst_n) begin
            n_cmd_ready = 1'b0;
            n_wr_ready  = 1'b0;
            n_rd_valid  = 1'b0;
            rq.delete();
        end else begin
            if (rd_taken) begin
                n_rd_valid = 1'b0;
                rd_taken   = 1'b0;
            end
            n_cmd_ready = ($urandom_range(0, 3) != 0);
            n_wr_ready  = ($urandom_range(0, 3) != 0);
            if (!n_rd_valid && rq.size() > 0 && $urandom_range(0, 2) != 0) begin
                n_rd_valid = 1'b1;
                n_rd_data  = nmem.exists(rq[0]) ? nmem[rq[0]] : '0;
            end
            #1;
            if (prev_stall)
                check(n_cmd_valid && n_cmd_addr == prev_addr, "R6", "stalled command held",
                      64'(n_cmd_addr), 64'(prev_addr));
            prev_stall = n_cmd_valid && !n_cmd_ready;
            prev_addr  = n_cmd_addr;
            if (u_rd_valid)
                check(!n_cmd_valid, "R7", "native command while result waits", 64'(n_cmd_valid), 64'd0);
            if (n_cmd_valid && n_cmd_ready) begin
                if (exp_addr.size() == 0) begin
                    check(1'b0, "R1", "unexpected narrow command", 64'(n_cmd_addr), 64'd0);
                end else begin
                    int ea;
                    bit ew;
                    ea = exp_addr.pop_front();
                    ew = exp_we.pop_front();
                    check(n_cmd_addr == NADDR_W'(ea), "R1", "narrow address", 64'(n_cmd_addr), 64'(ea));
                    check(n_cmd_we == ew, "R4", "narrow write flag", 64'(n_cmd_we), 64'(ew));
                end
                if (n_cmd_we) wqa.push_back(int'(n_cmd_addr));
                else rq.push_back(int'(n_cmd_addr));
            end
            if (n_wr_valid && n_wr_ready) begin
                if (exp_dat.size() == 0) begin
                    check(1'b0, "R2", "unexpected narrow data", 64'(n_wr_data), 64'd0);
                end else begin
                    logic [NARROW_W-1:0] ed;
                    logic [NB-1:0]       em;
                    ed = exp_dat.pop_front();
                    em = exp_msk.pop_front();
                    check(n_wr_data == ed, "R2", "narrow data slice", 64'(n_wr_data), 64'(ed));
                    check(n_wr_mask == em, "R2", "narrow mask slice", 64'(n_wr_mask), 64'(em));
                end
                wqd.push_back(n_wr_data);
                wqm.push_back(n_wr_mask);
            end
            while (wqa.size() > 0 && wqd.size() > 0) begin
                int                  a;
                logic [NARROW_W-1:0] d;
                logic [NB-1:0]       m;
                logic [NARROW_W-1:0] old;
                a   = wqa.pop_front();
                d   = wqd.pop_front();
                m   = wqm.pop_front();
                old = nmem.exists(a) ? nmem[a] : '0;
                for (int b = 0; b < NB; b++)
                    if (m[b]) old[b*8 +: 8] = d[b*8 +: 8];
                nmem[a] = old;
                nwr_beats++;
            end
            if (n_rd_valid && n_rd_ready) begin
                void'(rq.pop_front());
                rd_taken = 1'b1;
            end
        end
    end

    task automatic do_write(input int a, input logic [WIDE_W-1:0] d, input logic [WB-1:0] m, input int lag);
        logic [WIDE_W-1:0] old;
        @(negedge clk);
        u_cmd_valid = 1'b1;
        u_cmd_we    = 1'b1;
        u_cmd_addr  = ADDR_W'(a);
        for (int i = 0; i < RATIO; i++) begin
            exp_addr.push_back(a * RATIO + i);
            exp_we.push_back(1'b1);
            exp_dat.push_back(d[i*NARROW_W +: NARROW_W]);
            exp_msk.push_back(m[i*NB +: NB]);
        end
        nwr_beats = 0;
        for (int k = 0; k < lag; k++) begin
            #1;
            check(!n_cmd_valid && !u_cmd_ready, "R9", "write started without data",
                  64'({n_cmd_valid, u_cmd_ready}), 64'd0);
            @(negedge clk);
        end
        u_wr_valid = 1'b1;
        u_wr_data  = d;
        u_wr_mask  = m;
        #1;
        while (!u_cmd_ready) begin
            @(negedge clk);
            #1;
        end
        check(nwr_beats == RATIO, "R3", "narrow beats done at command ack", 64'(nwr_beats), 64'(RATIO));
        check(!u_wr_ready, "R3", "data ack not with command ack", 64'(u_wr_ready), 64'd0);
        @(negedge clk);
        u_cmd_valid = 1'b0;
        #1;
        check(u_wr_ready && !u_cmd_ready, "R3", "data ack one cycle after command ack",
              64'({u_wr_ready, u_cmd_ready}), 64'b10);
        @(negedge clk);
        u_wr_valid = 1'b0;
        old = wref.exists(a) ? wref[a] : '0;
        for (int b = 0; b < WB; b++)
            if (m[b]) old[b*8 +: 8] = d[b*8 +: 8];
        wref[a] = old;
    endtask

    task automatic do_read(input int a, input int hold);
        logic [WIDE_W-1:0] first;
        logic [WIDE_W-1:0] expd;
        @(negedge clk);
        u_cmd_valid = 1'b1;
        u_cmd_we    = 1'b0;
        u_cmd_addr  = ADDR_W'(a);
        for (int i = 0; i < RATIO; i++) begin
            exp_addr.push_back(a * RATIO + i);
            exp_we.push_back(1'b0);
        end
        #1;
        while (!u_cmd_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        u_cmd_valid = 1'b0;
        #1;
        while (!u_rd_valid) begin
            @(negedge clk);
            #1;
        end
        first = u_rd_data;
        for (int h = 0; h < hold; h++) begin
            @(negedge clk);
            u_cmd_valid = 1'b1;
            u_cmd_addr  = ADDR_W'(a + 1);
            #1;
            check(u_rd_valid && u_rd_data == first, "R5", "held read result", u_rd_data, first);
            check(!u_cmd_ready, "R7", "new command refused while busy", 64'(u_cmd_ready), 64'd0);
        end
        @(negedge clk);
        u_cmd_valid = 1'b0;
        u_rd_ready  = 1'b1;
        #1;
        expd = wref.exists(a) ? wref[a] : '0;
        check(u_rd_valid && u_rd_data == expd, "R4", "wide read result", u_rd_data, expd);
        @(negedge clk);
        u_rd_ready = 1'b0;
        #1;
        check(!u_rd_valid, "R4", "single wide beat per read", 64'(u_rd_valid), 64'd0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        void'($urandom(7));
        repeat (3) @(negedge clk);
        #1;
        check(!u_cmd_ready && !u_wr_ready && !u_rd_valid && !n_cmd_valid && !n_wr_valid && !n_rd_ready,
              "R8", "outputs low in reset",
              64'({u_cmd_ready, u_wr_ready, u_rd_valid, n_cmd_valid, n_wr_valid, n_rd_ready}), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!u_cmd_ready && !u_wr_ready && !u_rd_valid && !n_cmd_valid && !n_wr_valid && !n_rd_ready,
              "R8", "outputs low after reset",
              64'({u_cmd_ready, u_wr_ready, u_rd_valid, n_cmd_valid, n_wr_valid, n_rd_ready}), 64'd0);
        // Writes to distinct addresses, one partial mask, some with late data
        for (int i = 0; i < 10; i++) begin
            logic [WIDE_W-1:0] d;
            d = {$urandom(), $urandom()};
            do_write(i * 3 + 5, d, (i == 4) ? WB'(8'hA5) : '1, (i % 4 == 2) ? 4 : 0);
        end
        do_write(0, 64'h0123_4567_89AB_CDEF, '1, 0);
        do_write(16'hFFFF, 64'hFEDC_BA98_7654_3210, '1, 1);
        // Read back in reverse, with varying user stalls
        do_read(16'hFFFF, 2);
        do_read(0, 0);
        for (int i = 9; i >= 0; i--) do_read(i * 3 + 5, i % 3);
        do_read(1, 1);
        repeat (4) @(negedge clk);
        check(exp_addr.size() == 0, "R4", "all expected narrow commands issued", 64'(exp_addr.size()), 64'd0);
        // Narrow memory against the wide reference, slice by slice
        foreach (wref[a]) begin
            for (int i = 0; i < RATIO; i++) begin
                logic [NARROW_W-1:0] got;
                got = nmem.exists(a * RATIO + i) ? nmem[a * RATIO + i] : '0;
                check(got == wref[a][i*NARROW_W +: NARROW_W], "R2", "narrow memory slice",
                      64'(got), 64'(wref[a][i*NARROW_W +: NARROW_W]));
            end
        end
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

endmodule